// File: doc/BRIEF.md
# Burst Data Acknowledge Generator

This block sits on the target side of a split-transaction processor bus. It drives the per-beat data acknowledge for single-beat and four-beat burst transfers. A transfer begins with a one-cycle start strobe, which comes with a read/write flag and a burst flag. From that point the block holds the transfer open. Once the processor's minimum wait has passed, it acknowledges one beat in each cycle where the memory side reports data ready. It closes the transfer after the last beat.

The minimum number of wait states between the start cycle and the first acknowledge depends on two static configuration inputs: the bus-to-core clock ratio and whether data-retry is disabled. The wait only applies to burst reads. The memory side can also end a transfer early by raising an error input. The block then issues an error acknowledge in place of any data acknowledge and drops the transfer.

Top module: `burst_ack_gen`

## Requirements
- R1: After synchronous active-low reset, `ack`, `err_ack` and `busy` are all 0.
- R2: A `xfer_start` sampled while `busy` is 0 opens a transfer, and `busy` is 1 from the next cycle. A transfer is a burst of 4 beats when `xfer_burst`=1, and a single beat otherwise.
- R3: A single-beat transfer gives exactly one `ack`, and `busy` is 0 in the cycle after that acknowledge.
- R4: A burst transfer gives exactly four `ack` cycles, and `busy` is 0 in the cycle after the fourth one.
- R5: `ack` is 1 only in a cycle where `busy`=1, the minimum wait has elapsed, `mem_ready`=1 and `mem_error`=0. Holding `mem_ready` at 0 inserts wait states between beats.
- R6: The minimum wait W is the number of cycles strictly between the start cycle and the first possible `ack`. The `cfg_ratio` encoding is 0 = 1:1, 1 = 1.5:1, 2 and 3 = slower ratios. For a burst read (`xfer_read`=1, `xfer_burst`=1), W is 1 at ratio 1:1 with retry enabled, 2 at ratio 1:1 with `cfg_noretry`=1, 1 at ratio 1.5:1 with `cfg_noretry`=1, and 0 at ratio 1.5:1 with retry enabled. W is 0 for every write, every single-beat transfer and ratio codes 2 and 3.
- R7: `err_ack` equals `busy` AND `mem_error`, whether the transfer is in a wait state or mid-burst. In that cycle `ack` is 0, and `busy` is 0 in the next cycle. `mem_error` has no effect while idle.
- R8: A `xfer_start` sampled while `busy`=1 is ignored. This includes the cycle of the last beat. The running transfer keeps its beat count, and no new transfer opens.
- R9: After the last beat, `ack` stays 0 even when `mem_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ratio | input | 2 | Static clock ratio code (0 = 1:1, 1 = 1.5:1, 2/3 = slower) |
| cfg_noretry | input | 1 | Static: 1 = data-retry disabled |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_read | input | 1 | 1 = read, 0 = write |
| xfer_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| mem_ready | input | 1 | Memory side has the current beat ready |
| mem_error | input | 1 | Memory side signals a bus error |
| ack | output | 1 | Data acknowledge, one cycle per beat |
| err_ack | output | 1 | Error acknowledge, ends the transfer |
| busy | output | 1 | A transfer is open |

## Verification
`ack` and `err_ack` answer in the same cycle as `mem_ready` and `mem_error`. `busy` rises one edge after an accepted start and falls one edge after the final beat or error. With `mem_ready` held high, the first acknowledge is due W+1 cycles after the start cycle and the last one W+beats cycles after it, and `busy` is due low one cycle after the last one. The bench changes inputs on the falling edge and samples 1 ns before the next rising edge. Each sample is matched against the cycle index computed from these offsets.

// File: rtl/bag_pkg.sv
// Package: shared types and sizes for the burst acknowledge generator.
// Assumes the ratio code is static while any transfer is open.
package bag_pkg;
    localparam int WAIT_W = 2;

    typedef enum logic [1:0] {
        RATIO_1TO1 = 2'd0,
        RATIO_3TO2 = 2'd1,
        RATIO_2TO1 = 2'd2,
        RATIO_SLOW = 2'd3
    } ratio_e;
endpackage

// File: rtl/bag_wait_calc.sv
// Module: works out the minimum wait states before the first acknowledge.
// Assumes its inputs are stable in the cycle the start strobe is taken.
module bag_wait_calc
    import bag_pkg::*;
(
    input  ratio_e             ratio,
    input  logic               noretry,
    input  logic               is_read,
    input  logic               is_burst,
    output logic [WAIT_W-1:0]  wait_cycles
);
    // Purpose: pick the wait count from ratio, retry mode and transfer kind.
    always_comb begin
        wait_cycles = '0;
        if (is_read && is_burst) begin
            unique case (ratio)
                RATIO_1TO1: wait_cycles = noretry ? WAIT_W'(2) : WAIT_W'(1);
                RATIO_3TO2: wait_cycles = noretry ? WAIT_W'(1) : WAIT_W'(0);
                default:    wait_cycles = '0;
            endcase
        end
    end
endmodule

// File: rtl/bag_wait_timer.sv
// Module: down-counter that reports when the minimum wait has elapsed.
// Assumes load is pulsed in the start cycle. done is high once the count is zero.
module bag_wait_timer #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    logic [WIDTH-1:0] cnt_q;

    // Purpose: load on start, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/bag_beat_ctr.sv
// Module: counts acknowledged beats and flags the last beat of a transfer.
// Assumes clear is pulsed at each accepted start and step once per acknowledge.
module bag_beat_ctr #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic is_burst,
    output logic last
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Purpose: clear at start, advance by one per acknowledged beat.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    assign last = !is_burst || (cnt_q == CNT_W'(BEATS - 1));
endmodule

// File: rtl/burst_ack_gen.sv
// Module: top of the burst data acknowledge generator.
// It opens a transfer on an idle start strobe and holds off acknowledges for the
// minimum wait. After that it acknowledges one beat per data-ready cycle and closes
// after the final beat or an error.
// Assumes cfg_ratio and cfg_noretry are static and that mem_ready and mem_error
// are synchronous to clk.
module burst_ack_gen
    import bag_pkg::*;
#(
    parameter int BURST_BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_ratio,
    input  logic       cfg_noretry,
    input  logic       xfer_start,
    input  logic       xfer_read,
    input  logic       xfer_burst,
    input  logic       mem_ready,
    input  logic       mem_error,
    output logic       ack,
    output logic       err_ack,
    output logic       busy
);
    logic              busy_q;
    logic              burst_q;
    logic              accept;
    logic              wait_done;
    logic              beat_last;
    logic [WAIT_W-1:0] wait_val;

    assign accept = xfer_start && !busy_q;

    bag_wait_calc u_calc (
        .ratio       (ratio_e'(cfg_ratio)),
        .noretry     (cfg_noretry),
        .is_read     (xfer_read),
        .is_burst    (xfer_burst),
        .wait_cycles (wait_val)
    );

    bag_wait_timer #(.WIDTH(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_val),
        .done     (wait_done)
    );

    bag_beat_ctr #(.BEATS(BURST_BEATS)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (ack),
        .is_burst (burst_q),
        .last     (beat_last)
    );

    // Purpose: error acknowledge takes priority over the data acknowledge.
    always_comb begin
        err_ack = busy_q && mem_error;
        ack     = busy_q && wait_done && mem_ready && !mem_error;
    end

    // Purpose: transfer open/close state and the latched burst flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            burst_q <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            burst_q <= xfer_burst;
        end else if (err_ack || (ack && beat_last)) begin
            busy_q  <= 1'b0;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/bag_checker.sv
// Module: assertion checker for burst_ack_gen, attached by bind below.
// It keeps its own cycle count since start and its own acknowledge count.
module bag_checker #(
    parameter int BURST_BEATS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_ratio,
    input logic       cfg_noretry,
    input logic       xfer_start,
    input logic       xfer_read,
    input logic       xfer_burst,
    input logic       mem_ready,
    input logic       mem_error,
    input logic       ack,
    input logic       err_ack,
    input logic       busy
);
    logic [2:0] since_q;
    logic [2:0] need_q;
    logic [7:0] acks_q;
    logic       burst_seen_q;
    logic       take;
    logic [2:0] need_now;

    assign take = xfer_start && !busy;

    // Purpose: required wait derived independently from the requirement table.
    always_comb begin
        need_now = 3'd0;
        if (xfer_read && xfer_burst && cfg_ratio == 2'd0) need_now = cfg_noretry ? 3'd2 : 3'd1;
        if (xfer_read && xfer_burst && cfg_ratio == 2'd1 && cfg_noretry) need_now = 3'd1;
    end

    // Purpose: track cycles since start and acknowledges per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q      <= 3'd0;
            need_q       <= 3'd0;
            acks_q       <= 8'd0;
            burst_seen_q <= 1'b0;
        end else if (take) begin
            since_q      <= 3'd1;
            need_q       <= need_now;
            acks_q       <= 8'd0;
            burst_seen_q <= xfer_burst;
        end else begin
            if (since_q != 3'd7) since_q <= since_q + 3'd1;
            if (ack)             acks_q  <= acks_q + 8'd1;
        end
    end

    p_ack_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_ready && busy && !mem_error));

    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |-> !ack);

    p_err_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |=> !busy);

    p_min_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (since_q > need_q));

    p_beat_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (acks_q < (burst_seen_q ? 8'(BURST_BEATS) : 8'd1)));

    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
endmodule

bind burst_ack_gen bag_checker #(.BURST_BEATS(BURST_BEATS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ratio   (cfg_ratio),
    .cfg_noretry (cfg_noretry),
    .xfer_start  (xfer_start),
    .xfer_read   (xfer_read),
    .xfer_burst  (xfer_burst),
    .mem_ready   (mem_ready),
    .mem_error   (mem_error),
    .ack         (ack),
    .err_ack     (err_ack),
    .busy        (busy)
);

// File: tb/tb_burst_ack_gen.sv
`timescale 1ns/1ps
module tb_burst_ack_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_ratio = 2'd0;
    logic       cfg_noretry = 1'b0;
    logic       xfer_start = 1'b0;
    logic       xfer_read = 1'b0;
    logic       xfer_burst = 1'b0;
    logic       mem_ready = 1'b0;
    logic       mem_error = 1'b0;
    logic       ack;
    logic       err_ack;
    logic       busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_ack_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio), .cfg_noretry(cfg_noretry),
        .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_burst(xfer_burst),
        .mem_ready(mem_ready), .mem_error(mem_error),
        .ack(ack), .err_ack(err_ack), .busy(busy)
    );

    // vector: [7:6] ratio, [5] noretry, [4] read, [3] burst, [2:0] expected wait
    localparam logic [7:0] VEC [10] = '{
        {2'd0, 1'b0, 1'b1, 1'b1, 3'd1},
        {2'd0, 1'b1, 1'b1, 1'b1, 3'd2},
        {2'd1, 1'b1, 1'b1, 1'b1, 3'd1},
        {2'd1, 1'b0, 1'b1, 1'b1, 3'd0},
        {2'd0, 1'b1, 1'b0, 1'b1, 3'd0},
        {2'd0, 1'b1, 1'b1, 1'b0, 3'd0},
        {2'd2, 1'b1, 1'b1, 1'b1, 3'd0},
        {2'd3, 1'b0, 1'b1, 1'b1, 3'd0},
        {2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {2'd1, 1'b1, 1'b0, 1'b0, 3'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns before the rising edge
    task automatic step_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic open_xfer(input logic [1:0] r, input logic nr, input logic rd, input logic bu);
        @(negedge clk);
        cfg_ratio = r; cfg_noretry = nr; xfer_read = rd; xfer_burst = bu;
        xfer_start = 1'b1;
        #1;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mem_ready = 1'b1;
        mem_error = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mem_error = 1'b0;
        #1;
        // R1 reset state, mem_ready high while idle
        chk(ack == 1'b0,     "R1 ack after reset", ack, 0);
        chk(err_ack == 1'b0, "R1 err_ack after reset", err_ack, 0);
        chk(busy == 1'b0,    "R1 busy after reset", busy, 0);

        // R2 R3 R4 R6 R9 table walk, mem_ready held high
        foreach (VEC[i]) begin
            int w, beats, first, nack, endc;
            w     = int'(VEC[i][2:0]);
            beats = VEC[i][3] ? 4 : 1;
            first = -1; nack = 0; endc = -1;
            mem_ready = 1'b1;
            open_xfer(VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3]);
            for (int n = 1; n <= 12; n++) begin
                @(negedge clk);
                xfer_start = 1'b0;
                #1;
                if (n == 1) chk(busy == 1'b1, "R2 busy after start", busy, 1);
                if (ack) begin
                    if (first < 0) first = n;
                    nack++;
                end
                if (!busy && endc < 0) endc = n;
            end
            chk(first == w + 1, $sformatf("R6 first ack cycle vec %0d", i), first, w + 1);
            chk(nack == beats, VEC[i][3] ? "R4 burst ack count, R9 none after last" :
                               "R3 single ack count, R9 none after last", nack, beats);
            chk(endc == w + beats + 1, $sformatf("R4 R3 busy low cycle vec %0d", i), endc, w + beats + 1);
        end

        // R5 ready gating: ratio 1.5:1, retry on, burst read, W=0
        begin
            logic rdy [8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            logic exp [8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            open_xfer(2'd1, 1'b0, 1'b1, 1'b1);
            for (int n = 1; n <= 8; n++) begin
                @(negedge clk);
                xfer_start = 1'b0;
                mem_ready = rdy[n-1];
                #1;
                chk(ack == exp[n-1], $sformatf("R5 ack gated by ready cycle %0d", n), ack, exp[n-1]);
            end
            chk(busy == 1'b0, "R5 busy low after fourth beat", busy, 0);
        end

        // R5 wait gating: 1:1 no-retry burst read, ready high through wait
        mem_ready = 1'b1;
        open_xfer(2'd0, 1'b1, 1'b1, 1'b1);
        step_cycle(); xfer_start = 1'b0;
        chk(ack == 1'b0, "R5 no ack in first wait state", ack, 0);
        step_cycle();
        chk(ack == 1'b0, "R5 no ack in second wait state", ack, 0);
        step_cycle();
        chk(ack == 1'b1, "R5 ack after wait", ack, 1);
        repeat (4) step_cycle();

        // R7 error mid-burst
        open_xfer(2'd1, 1'b0, 1'b1, 1'b1);
        step_cycle(); xfer_start = 1'b0;
        step_cycle();
        @(negedge clk); mem_error = 1'b1; #1;
        chk(err_ack == 1'b1, "R7 err_ack mid-burst", err_ack, 1);
        chk(ack == 1'b0,     "R7 ack suppressed by error", ack, 0);
        @(negedge clk); #1;
        chk(busy == 1'b0,    "R7 busy low after error", busy, 0);
        chk(err_ack == 1'b0, "R7 error ignored while idle", err_ack, 0);
        @(negedge clk); mem_error = 1'b0; #1;
        chk(ack == 1'b0,     "R7 no ack after error end", ack, 0);

        // R7 error during wait state
        open_xfer(2'd0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); xfer_start = 1'b0; mem_error = 1'b1; #1;
        chk(err_ack == 1'b1, "R7 err_ack in wait state", err_ack, 1);
        @(negedge clk); mem_error = 1'b0; #1;
        chk(busy == 1'b0,    "R7 busy low after wait error", busy, 0);
        repeat (3) step_cycle();
        chk(ack == 1'b0,     "R7 no late ack after wait error", ack, 0);

        // R8 start while busy ignored, including the last-beat cycle
        begin
            int nack;
            nack = 0;
            open_xfer(2'd1, 1'b0, 1'b1, 1'b1);
            for (int n = 1; n <= 7; n++) begin
                @(negedge clk);
                xfer_start = (n >= 2 && n <= 4);
                xfer_burst = 1'b0;
                #1;
                if (ack) nack++;
                if (n == 5) chk(busy == 1'b0, "R8 busy low after burst", busy, 0);
                if (n == 6) chk(busy == 1'b0, "R8 last-beat start ignored", busy, 0);
            end
            chk(nack == 4, "R8 burst kept four beats", nack, 4);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule